// File: doc/BRIEF.md
# Charge Pump Speed-Up Controller

This block drives the digital scale codes of the two charge pumps in a fractional-N PLL. One pump feeds the proportional term of the loop filter and the other feeds the integral term. In normal operation the proportional pump runs at unit current and the integral pump is off. During a frequency change the loop bandwidth is widened. A rising edge on the serial-bus strobe that loads one of the two tuning words starts speed-up mode. In this mode the proportional code is raised to a power of two, and the integral pump is switched on at a programmable multiple of that raised value.

Speed-up mode ends as soon as the strobe falls. The two programmed fields are captured at the qualifying strobe edge, so the scale codes cannot change while speed-up mode is active. The block also routes the phase detector's up and down pulses to the pumps. The integral pump receives them only while speed-up mode is active. An up pulse always means raise the VCO frequency, and a down pulse always means lower it.

Top module: `cp_boost_ctrl`

## Requirements
- R1: Out of reset, and whenever speed-up mode is inactive, `boost_o`=0, `prop_mult_o`=1, `int_mult_o`=0 and `int_en_o`=0.
- R2: A strobe rising edge, meaning `strobe_i`=1 in a cycle after a cycle with `strobe_i`=0, enters speed-up mode if `word_sel_i` is 0 or 1 in that cycle. `boost_o`=1 and `int_en_o`=1 from the next cycle on.
- R3: Speed-up mode is held while `strobe_i` stays high. It ends in the cycle after `strobe_i` is sampled low, and R1 values then apply.
- R4: In speed-up mode `prop_mult_o` = 2^(L+1). L is the 2-bit `l_code_i` captured at entry, so the output is 2, 4, 8 or 16.
- R5: In speed-up mode `int_mult_o` = K × `prop_mult_o`, where K is the 4-bit `k_code_i` captured at entry. The largest value is 240 (K=15, L=3). K=0 gives 0 while `int_en_o` stays 1.
- R6: A strobe rising edge with `word_sel_i` equal to 2 or 3 does not enter speed-up mode. A later change of `word_sel_i` to 0 or 1 while the strobe stays high does not enter it either.
- R7: `l_code_i` and `k_code_i` are captured only at a qualifying rising edge. Changes to them during speed-up mode leave both multipliers unchanged.
- R8: `prop_up_o`/`prop_dn_o` always follow `pd_up_i`/`pd_dn_i`. `int_up_o`/`int_dn_o` follow the same inputs only in speed-up mode and are 0 otherwise. Up means raise the VCO frequency and down means lower it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe_i | input | 1 | Serial-bus load strobe |
| word_sel_i | input | 2 | Type of word being loaded (0, 1 = tuning words) |
| l_code_i | input | 2 | Proportional boost exponent field L |
| k_code_i | input | 4 | Integral ratio field K |
| pd_up_i | input | 1 | Phase detector up pulse |
| pd_dn_i | input | 1 | Phase detector down pulse |
| boost_o | output | 1 | Speed-up mode active |
| prop_mult_o | output | 5 | Proportional pump current multiplier |
| int_en_o | output | 1 | Integral pump enable |
| int_mult_o | output | 8 | Integral pump multiplier relative to unit current |
| prop_up_o | output | 1 | Proportional pump up (raise VCO) |
| prop_dn_o | output | 1 | Proportional pump down (lower VCO) |
| int_up_o | output | 1 | Integral pump up (raise VCO) |
| int_dn_o | output | 1 | Integral pump down (lower VCO) |

## Verification
The assertions check the following on every cycle:
- the unit-current values outside speed-up mode;
- the one-hot shape of the proportional code;
- that the integral code is the captured K times the proportional code;
- the exit one cycle after the strobe falls;
- the entry on a qualifying edge;
- the gating of the integral pump's pulses.

Only the bench scenarios can show that the captured fields are the ones present at the edge rather than later values, that the word type changing mid-strobe is ignored, and that the exact codes (2 through 240) come out for chosen L and K.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
    localparam int unsigned CPB_L_W    = 2;
    localparam int unsigned CPB_K_W    = 4;
    localparam int unsigned CPB_SEL_W  = 2;
    localparam int unsigned CPB_SEL_PRI = 0;
    localparam int unsigned CPB_SEL_SEC = 1;
endpackage

// File: rtl/cpb_entry_qual.sv
// Decides entry into and persistence of speed-up mode from the strobe level,
// its previous sample and the word-type code.
module cpb_entry_qual #(
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned SEL_PRI = 0,
    parameter int unsigned SEL_SEC = 1
) (
    input  logic             strobe_i,
    input  logic             strobe_prev_i,
    input  logic [SEL_W-1:0] word_sel_i,
    input  logic             boost_q_i,
    output logic             enter_o,
    output logic             boost_d_o
);
    logic word_ok;

    generate
        if (SEL_PRI == SEL_SEC) begin : g_single
            assign word_ok = (word_sel_i == SEL_W'(SEL_PRI));
        end else begin : g_pair
            assign word_ok = (word_sel_i == SEL_W'(SEL_PRI)) ||
                             (word_sel_i == SEL_W'(SEL_SEC));
        end
    endgenerate

    assign enter_o   = strobe_i && !strobe_prev_i && word_ok;
    assign boost_d_o = enter_o || (boost_q_i && strobe_i);
endmodule

// File: rtl/cpb_scale_calc.sv
// Maps mode and captured fields to the two pump multiplier codes.
module cpb_scale_calc #(
    parameter int unsigned LW  = 2,
    parameter int unsigned KW  = 4,
    parameter int unsigned PMW = 5,
    parameter int unsigned IMW = 8
) (
    input  logic           boost_i,
    input  logic [LW-1:0]  l_i,
    input  logic [KW-1:0]  k_i,
    output logic [PMW-1:0] pmult_o,
    output logic [IMW-1:0] imult_o
);
    logic [LW:0]    shamt;
    logic [PMW-1:0] boosted;

    always_comb begin
        shamt   = {1'b0, l_i} + (LW+1)'(1);
        boosted = PMW'(1) << shamt;
        if (boost_i) begin
            pmult_o = boosted;
            imult_o = IMW'(boosted) * IMW'(k_i);
        end else begin
            pmult_o = PMW'(1);
            imult_o = '0;
        end
    end
endmodule

// File: rtl/cpb_pump_steer.sv
// Routes phase-detector pulses: up raises VCO frequency, down lowers it.
module cpb_pump_steer (
    input  logic boost_i,
    input  logic pd_up_i,
    input  logic pd_dn_i,
    output logic prop_up_o,
    output logic prop_dn_o,
    output logic int_up_o,
    output logic int_dn_o
);
    assign prop_up_o = pd_up_i;
    assign prop_dn_o = pd_dn_i;
    assign int_up_o  = pd_up_i && boost_i;
    assign int_dn_o  = pd_dn_i && boost_i;
endmodule

// File: rtl/cp_boost_ctrl.sv
module cp_boost_ctrl #(
    parameter int unsigned LW      = cpb_pkg::CPB_L_W,
    parameter int unsigned KW      = cpb_pkg::CPB_K_W,
    parameter int unsigned SEL_W   = cpb_pkg::CPB_SEL_W,
    parameter int unsigned SEL_PRI = cpb_pkg::CPB_SEL_PRI,
    parameter int unsigned SEL_SEC = cpb_pkg::CPB_SEL_SEC,
    localparam int unsigned PMW    = (2**LW) + 1,
    localparam int unsigned IMW    = (2**LW) + KW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe_i,
    input  logic [SEL_W-1:0] word_sel_i,
    input  logic [LW-1:0]    l_code_i,
    input  logic [KW-1:0]    k_code_i,
    input  logic             pd_up_i,
    input  logic             pd_dn_i,
    output logic             boost_o,
    output logic [PMW-1:0]   prop_mult_o,
    output logic             int_en_o,
    output logic [IMW-1:0]   int_mult_o,
    output logic             prop_up_o,
    output logic             prop_dn_o,
    output logic             int_up_o,
    output logic             int_dn_o
);
    typedef struct packed {
        logic           strb;
        logic           boost;
        logic [LW-1:0]  l;
        logic [KW-1:0]  k;
        logic [PMW-1:0] pmult;
        logic [IMW-1:0] imult;
    } cpb_state_t;

    cpb_state_t state_d, state_q;

    logic           enter;
    logic           boost_nx;
    logic [LW-1:0]  l_nx;
    logic [KW-1:0]  k_nx;
    logic [PMW-1:0] pmult_nx;
    logic [IMW-1:0] imult_nx;
    logic [KW-1:0]  k_lat_q;

    cpb_entry_qual #(
        .SEL_W  (SEL_W),
        .SEL_PRI(SEL_PRI),
        .SEL_SEC(SEL_SEC)
    ) u_qual (
        .strobe_i     (strobe_i),
        .strobe_prev_i(state_q.strb),
        .word_sel_i   (word_sel_i),
        .boost_q_i    (state_q.boost),
        .enter_o      (enter),
        .boost_d_o    (boost_nx)
    );

    assign l_nx = enter ? l_code_i : state_q.l;
    assign k_nx = enter ? k_code_i : state_q.k;

    cpb_scale_calc #(
        .LW (LW),
        .KW (KW),
        .PMW(PMW),
        .IMW(IMW)
    ) u_scale (
        .boost_i(boost_nx),
        .l_i    (l_nx),
        .k_i    (k_nx),
        .pmult_o(pmult_nx),
        .imult_o(imult_nx)
    );

    always_comb begin
        state_d       = state_q;
        state_d.strb  = strobe_i;
        state_d.boost = boost_nx;
        state_d.l     = l_nx;
        state_d.k     = k_nx;
        state_d.pmult = pmult_nx;
        state_d.imult = imult_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.strb  <= 1'b0;
            state_q.boost <= 1'b0;
            state_q.l     <= '0;
            state_q.k     <= '0;
            state_q.pmult <= PMW'(1);
            state_q.imult <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    cpb_pump_steer u_steer (
        .boost_i  (state_q.boost),
        .pd_up_i  (pd_up_i),
        .pd_dn_i  (pd_dn_i),
        .prop_up_o(prop_up_o),
        .prop_dn_o(prop_dn_o),
        .int_up_o (int_up_o),
        .int_dn_o (int_dn_o)
    );

    assign boost_o     = state_q.boost;
    assign int_en_o    = state_q.boost;
    assign prop_mult_o = state_q.pmult;
    assign int_mult_o  = state_q.imult;
    assign k_lat_q     = state_q.k;
endmodule

// File: rtl/cpb_checker.sv
module cpb_checker #(
    parameter int unsigned LW      = 2,
    parameter int unsigned KW      = 4,
    parameter int unsigned SEL_W   = 2,
    parameter int unsigned SEL_PRI = 0,
    parameter int unsigned SEL_SEC = 1,
    parameter int unsigned PMW     = 5,
    parameter int unsigned IMW     = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             strobe_i,
    input logic [SEL_W-1:0] word_sel_i,
    input logic             pd_up_i,
    input logic             pd_dn_i,
    input logic             boost_o,
    input logic [PMW-1:0]   prop_mult_o,
    input logic             int_en_o,
    input logic [IMW-1:0]   int_mult_o,
    input logic             prop_up_o,
    input logic             prop_dn_o,
    input logic             int_up_o,
    input logic             int_dn_o,
    input logic [KW-1:0]    k_lat
);
    logic qual_word;
    assign qual_word = (word_sel_i == SEL_W'(SEL_PRI)) || (word_sel_i == SEL_W'(SEL_SEC));

    a_r1_normal_unit: assert property (@(posedge clk) disable iff (!rst_n)
        !boost_o |-> (prop_mult_o == PMW'(1)) && (int_mult_o == '0) && !int_en_o);

    a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_i) && qual_word) |=> (boost_o && int_en_o));

    a_r3_exit: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_i |=> !boost_o);

    a_r4_prop_pow2: assert property (@(posedge clk) disable iff (!rst_n)
        boost_o |-> ($countones(prop_mult_o) == 1) && (prop_mult_o >= PMW'(2)));

    a_r5_int_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        boost_o |-> (int_mult_o == IMW'(prop_mult_o) * IMW'(k_lat)));

    a_r6_no_entry: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(strobe_i) && !qual_word && !boost_o) |=> !boost_o);

    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (boost_o && $past(boost_o)) |-> ($stable(prop_mult_o) && $stable(int_mult_o)));

    a_r8_steer: assert property (@(posedge clk) disable iff (!rst_n)
        (prop_up_o == pd_up_i) && (prop_dn_o == pd_dn_i) &&
        (int_up_o == (pd_up_i && boost_o)) && (int_dn_o == (pd_dn_i && boost_o)));
endmodule

bind cp_boost_ctrl cpb_checker #(
    .LW     (LW),
    .KW     (KW),
    .SEL_W  (SEL_W),
    .SEL_PRI(SEL_PRI),
    .SEL_SEC(SEL_SEC),
    .PMW    (PMW),
    .IMW    (IMW)
) u_cpb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe_i   (strobe_i),
    .word_sel_i (word_sel_i),
    .pd_up_i    (pd_up_i),
    .pd_dn_i    (pd_dn_i),
    .boost_o    (boost_o),
    .prop_mult_o(prop_mult_o),
    .int_en_o   (int_en_o),
    .int_mult_o (int_mult_o),
    .prop_up_o  (prop_up_o),
    .prop_dn_o  (prop_dn_o),
    .int_up_o   (int_up_o),
    .int_dn_o   (int_dn_o),
    .k_lat      (k_lat_q)
);

// File: tb/test_cp_boost_ctrl.sv
module test_cp_boost_ctrl;
    import cpb_pkg::*;

    localparam int PMW = (2**CPB_L_W) + 1;
    localparam int IMW = (2**CPB_L_W) + CPB_K_W;
    localparam int VW  = 2 + PMW + IMW + 4;

    typedef struct {
        logic [VW-1:0] v;
        string         req;
    } item_t;

    item_t q[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic strobe_i = 1'b0;
    logic [1:0] word_sel_i = '0;
    logic [1:0] l_code_i = '0;
    logic [3:0] k_code_i = '0;
    logic pd_up_i = 1'b0;
    logic pd_dn_i = 1'b0;
    logic boost_o, int_en_o, prop_up_o, prop_dn_o, int_up_o, int_dn_o;
    logic [PMW-1:0] prop_mult_o;
    logic [IMW-1:0] int_mult_o;

    int n_chk = 0;
    int n_err = 0;
    bit m_boost = 0;
    bit m_prev = 0;
    logic [1:0] m_l = '0;
    logic [3:0] m_k = '0;

    always #10 clk = ~clk;

    cp_boost_ctrl i_cp_boost_ctrl (
        .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .word_sel_i(word_sel_i),
        .l_code_i(l_code_i), .k_code_i(k_code_i), .pd_up_i(pd_up_i), .pd_dn_i(pd_dn_i),
        .boost_o(boost_o), .prop_mult_o(prop_mult_o), .int_en_o(int_en_o),
        .int_mult_o(int_mult_o), .prop_up_o(prop_up_o), .prop_dn_o(prop_dn_o),
        .int_up_o(int_up_o), .int_dn_o(int_dn_o)
    );

    function automatic logic [VW-1:0] actual_vec();
        return {boost_o, int_en_o, prop_mult_o, int_mult_o,
                prop_up_o, prop_dn_o, int_up_o, int_dn_o};
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected outputs.
    task automatic step(input logic s, input logic [1:0] w, input logic [1:0] l,
                        input logic [3:0] k, input logic up, input logic dn,
                        input string req);
        logic [PMW-1:0] pm;
        logic [IMW-1:0] im;
        bit enter;
        int sh;
        item_t it;
        @(negedge clk);
        strobe_i = s; word_sel_i = w; l_code_i = l; k_code_i = k;
        pd_up_i = up; pd_dn_i = dn;
        enter = s && !m_prev && (w == 2'd0 || w == 2'd1);
        m_boost = enter || (m_boost && s);
        if (enter) begin
            m_l = l;
            m_k = k;
        end
        m_prev = s;
        sh = int'(m_l) + 1;
        pm = m_boost ? PMW'(1 << sh) : PMW'(1);
        im = m_boost ? IMW'(int'(pm) * int'(m_k)) : '0;
        it.v = {m_boost, m_boost, pm, im, up, dn, up && m_boost, dn && m_boost};
        it.req = req;
        q.push_back(it);
    endtask

    // Monitor: pops expected items and compares after each clock edge.
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                n_chk++;
                if (actual_vec() !== it.v) begin
                    n_err++;
                    $display("FAIL %s: actual=%h expected=%h", it.req, actual_vec(), it.v);
                end
            end
        end
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        n_chk++;
        if (actual_vec() !== {1'b0, 1'b0, PMW'(1), IMW'(0), 4'b0000}) begin
            n_err++;
            $display("FAIL R1 reset: actual=%h expected=%h", actual_vec(),
                     {1'b0, 1'b0, PMW'(1), IMW'(0), 4'b0000});
        end
        rst_n = 1'b1;

        step(0, 2'd0, 2'd3, 4'd9, 0, 0, "R1 idle normal");
        step(0, 2'd1, 2'd2, 4'd7, 1, 0, "R8 normal up, integral gated");
        step(0, 2'd0, 2'd0, 4'd1, 0, 1, "R8 normal down, integral gated");
        // entry on primary word, L=0 K=1 -> 2, 2
        step(1, 2'd0, 2'd0, 4'd1, 0, 0, "R2 R4 entry primary L0");
        step(1, 2'd0, 2'd3, 4'd15, 1, 0, "R7 fields changed during boost");
        step(1, 2'd2, 2'd1, 4'd4, 0, 1, "R8 integral down in boost");
        step(1, 2'd0, 2'd2, 4'd2, 1, 0, "R3 held while strobe high");
        step(0, 2'd0, 2'd0, 4'd0, 1, 0, "R3 exit on strobe low");
        // secondary word, maximum
        step(1, 2'd1, 2'd3, 4'd15, 0, 0, "R5 maximum 240");
        step(1, 2'd1, 2'd0, 4'd0, 0, 0, "R7 hold maximum");
        step(0, 2'd1, 2'd0, 4'd0, 0, 0, "R3 exit");
        // K=0 with L=2
        step(1, 2'd0, 2'd2, 4'd0, 0, 0, "R5 K zero enabled");
        step(0, 2'd0, 2'd2, 4'd0, 0, 0, "R3 exit");
        // L=1 K=5
        step(1, 2'd1, 2'd1, 4'd5, 1, 1, "R4 R5 L1 K5");
        step(0, 2'd0, 2'd1, 4'd5, 0, 0, "R3 exit");
        // non-qualifying words
        step(1, 2'd2, 2'd3, 4'd3, 0, 0, "R6 word 2 no entry");
        step(1, 2'd0, 2'd3, 4'd3, 1, 0, "R6 word switched mid-strobe");
        step(1, 2'd1, 2'd3, 4'd3, 0, 1, "R6 still no entry");
        step(0, 2'd3, 2'd3, 4'd3, 0, 0, "R1 low");
        step(1, 2'd3, 2'd2, 4'd6, 0, 0, "R6 word 3 no entry");
        step(0, 2'd0, 2'd2, 4'd6, 0, 0, "R1 low");
        // re-entry after one-cycle low picks up new fields
        step(1, 2'd0, 2'd2, 4'd3, 0, 0, "R7 entry L2 K3");
        step(0, 2'd0, 2'd2, 4'd3, 0, 0, "R3 exit");
        step(1, 2'd1, 2'd0, 4'd12, 0, 0, "R7 re-entry new fields");
        step(0, 2'd1, 2'd0, 4'd12, 0, 0, "R3 exit");

        while (q.size() > 0) @(posedge clk);
        repeat (2) @(negedge clk);
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule